// File: doc/BRIEF.md
# Fused Read-Modify-Write Opcode Executor

This block carries out the combined (undocumented) memory opcodes of an 8-bit accumulator processor once the surrounding core has resolved the effective address. A single `start` pulse hands over the opcode, the effective address and the current accumulator, index and status values. The block then runs a short fixed sequence on a byte-wide memory port: read the operand, build the modified byte (shift, rotate, increment or decrement), write that byte back, and finally feed it into a dependent accumulator operation that updates the flags.

The opcodes handled are a decrement-then-compare, an increment-then-subtract, shift-left-then-OR, rotate-left-then-AND, shift-right-then-XOR, rotate-right-then-add, a load of both accumulator and index, a store of accumulator AND index, a subtract alias in the immediate column, and a family of read-only no-operations. Any other opcode finishes at once with no memory access. Updated register values appear on the outputs in the cycle `done` is high and stay there until the next accepted `start`.

Top module: `rmw_fused_exec`

## Requirements
- R1: After reset, `done`, `memRd` and `memWr` are low and `aOut`, `xOut`, `pOut` are zero. Status bits used: carry is bit 0, zero is bit 1, overflow is bit 6, negative is bit 7; every other status bit passes through unchanged for every opcode, and only the loading opcode changes `xOut`.
- R2: Decrement-compare (opcodes 0xC3, 0xC7, 0xCF, 0xD3, 0xD7, 0xDB, 0xDF) writes memory minus one (wrapping) to the effective address; carry becomes A >= new value (unsigned), zero and negative come from A minus the new value, A and overflow are unchanged.
- R3: Increment-subtract (0xE3, 0xE7, 0xEF, 0xF3, 0xF7, 0xFB, 0xFF) writes memory plus one (wrapping), then A becomes A + NOT(new) + carry; carry is bit 8 of that sum, overflow is set when both addends share a sign that differs from the result's sign, zero and negative come from the new A.
- R4: Shift-left-OR (0x03, 0x07, 0x0F, 0x13, 0x17, 0x1B, 0x1F) writes memory shifted left with a 0 in bit 0 and ORs it into A; shift-right-XOR (0x43, 0x47, 0x4F, 0x53, 0x57, 0x5B, 0x5F) writes memory shifted right with a 0 in bit 7 and XORs it into A. Carry takes the bit shifted out; zero and negative come from the new A.
- R5: Rotate-left-AND (0x23, 0x27, 0x2F, 0x33, 0x37, 0x3B, 0x3F) writes memory rotated left through carry and ANDs it into A, with carry taking old bit 7; rotate-right-add (0x63, 0x67, 0x6F, 0x73, 0x77, 0x7B, 0x7F) writes memory rotated right through carry, then A becomes A + rotated value + old bit 0, with carry and overflow from that sum as in R3; zero and negative come from the new A.
- R6: Load-both (0xA3, 0xA7, 0xAF, 0xB3, 0xB7, 0xBF) reads the byte into both A and X and sets zero and negative from it; no write.
- R7: Store-AND (0x83, 0x87, 0x8F, 0x97) writes A AND X to the effective address without reading it and leaves A, X and all status bits unchanged.
- R8: Opcode 0xEB reads the byte and computes A + NOT(byte) + carry exactly as in R3, with no write.
- R9: Read-only no-operations (0x04, 0x0C, 0x14, 0x1C, 0x34, 0x3C, 0x44, 0x54, 0x5C, 0x64, 0x74, 0x7C, 0xD4, 0xDC, 0xF4, 0xFC) perform one read of the effective address, no write, and change no register or status bit.
- R10: Any opcode not listed in R2 to R9 performs no memory access and changes nothing.
- R11: `done` is a one-cycle pulse in the Nth cycle after the cycle in which `start` is accepted, N being 5 for R2 to R5, 4 for R6 and R8, 3 for R9, 2 for R7 and 1 for R10. A read and a write are never requested together, each is issued at most once per operation, always at the effective address, and the read data is taken the cycle after `memRd`.
- R12: `start` is accepted only when the block is idle; a `start` during an operation, whatever the inputs then carry, changes neither its result nor its memory traffic and starts nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opcode | input | 8 | Opcode to execute |
| effAddr | input | AddrW | Resolved effective address |
| aIn | input | DataW | Accumulator value at start |
| xIn | input | DataW | Index value at start |
| pIn | input | 8 | Status value at start |
| memRData | input | DataW | Read data, valid the cycle after memRd |
| memAddr | output | AddrW | Memory address |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memWData | output | DataW | Write data |
| done | output | 1 | Operation finished, results valid |
| aOut | output | DataW | Updated accumulator |
| xOut | output | DataW | Updated index |
| pOut | output | 8 | Updated status |

## Verification
Random opcodes drawn mostly from the supported set, with random accumulator, index, status and memory bytes, separate the shift and rotate directions, the carry feed from the rotate into the following add, and the pass-through of unrelated status bits. Fully random bytes reach neighbouring unsupported opcodes in the same columns, which tells a correct decode from one that accepts too much. Directed cases pin the wrap of the decrement at 0x00 and the increment at 0xFF, the compare at equality, signed overflow in both add paths, a zero result from the load, and a second `start` issued mid-operation with different inputs.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int OpW   = 8;
  localparam int FlagW = 8;
  localparam int FlagC = 0;
  localparam int FlagZ = 1;
  localparam int FlagV = 6;
  localparam int FlagN = 7;

  typedef enum logic [3:0] {
    CL_NONE, CL_NOPR, CL_LAX, CL_SAX, CL_SBC,
    CL_SLO, CL_RLA, CL_SRE, CL_RRA, CL_DCP, CL_ISB
  } opClassE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // latch inputs
    logic rd;    // issue read
    logic cap;   // capture read data and build modified byte
    logic wr;    // issue write
    logic exe;   // accumulator / flag update
    logic fin;   // done cycle
  } strobeT;

  function automatic opClassE decodeOp(input logic [OpW-1:0] op);
    logic [2:0] grp;
    logic [2:0] sub;
    opClassE cls;
    grp = op[7:5];
    sub = op[4:2];
    cls = CL_NONE;
    if (op == 8'hEB) begin
      cls = CL_SBC;
    end else if (op[1:0] == 2'b11) begin
      case (grp)
        3'b000: if (sub != 3'b010) cls = CL_SLO;
        3'b001: if (sub != 3'b010) cls = CL_RLA;
        3'b010: if (sub != 3'b010) cls = CL_SRE;
        3'b011: if (sub != 3'b010) cls = CL_RRA;
        3'b100: if (sub inside {3'b000, 3'b001, 3'b011, 3'b101}) cls = CL_SAX;
        3'b101: if (!(sub inside {3'b010, 3'b110})) cls = CL_LAX;
        3'b110: if (sub != 3'b010) cls = CL_DCP;
        default: if (sub != 3'b010) cls = CL_ISB;
      endcase
    end else if (op[1:0] == 2'b00) begin
      case (op)
        8'h04, 8'h0C, 8'h14, 8'h1C, 8'h34, 8'h3C, 8'h44, 8'h54,
        8'h5C, 8'h64, 8'h74, 8'h7C, 8'hD4, 8'hDC, 8'hF4, 8'hFC: cls = CL_NOPR;
        default: cls = CL_NONE;
      endcase
    end
    return cls;
  endfunction

  function automatic logic isRmw(input opClassE c);
    return c inside {CL_SLO, CL_RLA, CL_SRE, CL_RRA, CL_DCP, CL_ISB};
  endfunction
endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  opClassE newClass,
  input  opClassE curClass,
  output strobeT  strobe
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_LATCH, S_WRITE, S_EXEC, S_FIN} stateE;
  stateE state, nxt;

  always_comb begin
    strobe = '0;
    nxt    = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          if (newClass == CL_SAX)       nxt = S_WRITE;
          else if (newClass == CL_NONE) nxt = S_FIN;
          else                          nxt = S_READ;
        end
      end
      S_READ: begin
        strobe.rd = 1'b1;
        nxt = S_LATCH;
      end
      S_LATCH: begin
        strobe.cap = 1'b1;
        if (isRmw(curClass))                                nxt = S_WRITE;
        else if (curClass == CL_LAX || curClass == CL_SBC)  nxt = S_EXEC;
        else                                                nxt = S_FIN;
      end
      S_WRITE: begin
        strobe.wr = 1'b1;
        nxt = (curClass == CL_SAX) ? S_FIN : S_EXEC;
      end
      S_EXEC: begin
        strobe.exe = 1'b1;
        nxt = S_FIN;
      end
      default: begin
        strobe.fin = 1'b1;
        nxt = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end
endmodule

// File: rtl/rmw_dpath.sv
module rmw_dpath
  import rmw_pkg::*;
#(
  parameter int DataW = 8,
  parameter int AddrW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  opClassE          newClass,
  input  logic [AddrW-1:0] effAddr,
  input  logic [DataW-1:0] aIn,
  input  logic [DataW-1:0] xIn,
  input  logic [FlagW-1:0] pIn,
  input  logic [DataW-1:0] memRData,
  output opClassE          curClass,
  output logic [AddrW-1:0] memAddr,
  output logic             memRd,
  output logic             memWr,
  output logic [DataW-1:0] memWData,
  output logic             done,
  output logic [DataW-1:0] aOut,
  output logic [DataW-1:0] xOut,
  output logic [FlagW-1:0] pOut
);
  localparam int Msb = DataW - 1;

  logic [DataW-1:0] aReg, xReg, modReg;
  logic [FlagW-1:0] pReg;
  logic [AddrW-1:0] addrReg;
  logic             shC;
  opClassE          clsReg;

  // modify step
  logic [DataW-1:0] modVal;
  logic             modC;
  always_comb begin
    modVal = memRData;
    modC   = pReg[FlagC];
    case (clsReg)
      CL_SLO: {modC, modVal} = {memRData, 1'b0};
      CL_RLA: {modC, modVal} = {memRData, pReg[FlagC]};
      CL_SRE: {modVal, modC} = {1'b0, memRData};
      CL_RRA: {modVal, modC} = {pReg[FlagC], memRData};
      CL_DCP: modVal = memRData - DataW'(1);
      CL_ISB: modVal = memRData + DataW'(1);
      default: ;
    endcase
  end

  // accumulator step
  logic [DataW-1:0] addB, diff, resA, resX, znSrc;
  logic             addCin, ovf;
  logic [DataW:0]   sum;
  logic [FlagW-1:0] resP;
  always_comb begin
    case (clsReg)
      CL_RRA:         begin addB = modReg;  addCin = shC;         end
      CL_ISB, CL_SBC: begin addB = ~modReg; addCin = pReg[FlagC]; end
      default:        begin addB = modReg;  addCin = pReg[FlagC]; end
    endcase
    sum  = {1'b0, aReg} + {1'b0, addB} + {{DataW{1'b0}}, addCin};
    ovf  = (aReg[Msb] == addB[Msb]) && (sum[Msb] != aReg[Msb]);
    diff = aReg - modReg;
    resA = aReg;
    resX = xReg;
    resP = pReg;
    case (clsReg)
      CL_SLO: begin resA = aReg | modReg; resP[FlagC] = shC; end
      CL_RLA: begin resA = aReg & modReg; resP[FlagC] = shC; end
      CL_SRE: begin resA = aReg ^ modReg; resP[FlagC] = shC; end
      CL_RRA, CL_ISB, CL_SBC: begin
        resA = sum[Msb:0];
        resP[FlagC] = sum[DataW];
        resP[FlagV] = ovf;
      end
      CL_DCP: resP[FlagC] = (aReg >= modReg);
      CL_LAX: begin resA = modReg; resX = modReg; end
      default: ;
    endcase
    znSrc = (clsReg == CL_DCP) ? diff : resA;
    if (clsReg inside {CL_SLO, CL_RLA, CL_SRE, CL_RRA, CL_ISB, CL_SBC, CL_DCP, CL_LAX}) begin
      resP[FlagZ] = (znSrc == '0);
      resP[FlagN] = znSrc[Msb];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      xReg    <= '0;
      pReg    <= '0;
      addrReg <= '0;
      modReg  <= '0;
      shC     <= 1'b0;
      clsReg  <= CL_NONE;
    end else begin
      if (strobe.load) begin
        aReg    <= aIn;
        xReg    <= xIn;
        pReg    <= pIn;
        addrReg <= effAddr;
        clsReg  <= newClass;
      end
      if (strobe.cap) begin
        modReg <= modVal;
        shC    <= modC;
      end
      if (strobe.exe) begin
        aReg <= resA;
        xReg <= resX;
        pReg <= resP;
      end
    end
  end

  assign curClass = clsReg;
  assign memAddr  = addrReg;
  assign memRd    = strobe.rd;
  assign memWr    = strobe.wr;
  assign memWData = (clsReg == CL_SAX) ? (aReg & xReg) : modReg;
  assign done     = strobe.fin;
  assign aOut     = aReg;
  assign xOut     = xReg;
  assign pOut     = pReg;
endmodule

// File: rtl/rmw_fused_exec.sv
module rmw_fused_exec
  import rmw_pkg::*;
#(
  parameter int DataW = 8,
  parameter int AddrW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OpW-1:0]   opcode,
  input  logic [AddrW-1:0] effAddr,
  input  logic [DataW-1:0] aIn,
  input  logic [DataW-1:0] xIn,
  input  logic [FlagW-1:0] pIn,
  input  logic [DataW-1:0] memRData,
  output logic [AddrW-1:0] memAddr,
  output logic             memRd,
  output logic             memWr,
  output logic [DataW-1:0] memWData,
  output logic             done,
  output logic [DataW-1:0] aOut,
  output logic [DataW-1:0] xOut,
  output logic [FlagW-1:0] pOut
);
  opClassE newClass, curClass;
  strobeT  strobe;

  assign newClass = decodeOp(opcode);

  rmw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .newClass(newClass), .curClass(curClass), .strobe(strobe)
  );

  rmw_dpath #(.DataW(DataW), .AddrW(AddrW)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newClass(newClass),
    .effAddr(effAddr), .aIn(aIn), .xIn(xIn), .pIn(pIn), .memRData(memRData),
    .curClass(curClass), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWData(memWData), .done(done), .aOut(aOut), .xOut(xOut), .pOut(pOut)
  );
endmodule

// File: rtl/rmw_fused_exec_chk.sv
module rmw_fused_exec_chk #(
  parameter int DataW = 8,
  parameter int AddrW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [7:0]       opcode,
  input logic [AddrW-1:0] effAddr,
  input logic [DataW-1:0] aIn,
  input logic [DataW-1:0] xIn,
  input logic [7:0]       pIn,
  input logic [DataW-1:0] memRData,
  input logic [AddrW-1:0] memAddr,
  input logic             memRd,
  input logic             memWr,
  input logic [DataW-1:0] memWData,
  input logic             done,
  input logic [DataW-1:0] aOut,
  input logic [DataW-1:0] xOut,
  input logic [7:0]       pOut
);
  logic             busy, rdPend;
  logic [7:0]       sOp, sP;
  logic [DataW-1:0] sA, sX, rdByte;
  logic [AddrW-1:0] sAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; rdPend <= 1'b0; rdByte <= '0;
      sOp <= '0; sP <= '0; sA <= '0; sX <= '0; sAddr <= '0;
    end else begin
      rdPend <= memRd;
      if (rdPend) rdByte <= memRData;
      if (done) begin
        busy <= 1'b0;
      end else if (start && !busy) begin
        busy <= 1'b1;
        sOp <= opcode; sP <= pIn; sA <= aIn; sX <= xIn; sAddr <= effAddr;
      end
    end
  end

  logic laxOp, saxCol, nopCol;
  assign laxOp  = (sOp[1:0] == 2'b11) && (sOp[7:5] == 3'b101) &&
                  (sOp[4:2] != 3'b010) && (sOp[4:2] != 3'b110);
  assign saxCol = (sOp[1:0] == 2'b11) && (sOp[7:5] == 3'b100);
  assign nopCol = (sOp[1:0] == 2'b00);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_no_rd_wr_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  p_access_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (busy && memAddr == sAddr));
  p_x_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !laxOp) |-> (xOut == sX));
  p_lax_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && laxOp) |-> (aOut == rdByte && xOut == rdByte));
  p_sax_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && saxCol) |-> (memWData == (sA & sX)));
  p_nop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && nopCol) |-> (aOut == sA && pOut == sP));
endmodule

bind rmw_fused_exec rmw_fused_exec_chk #(.DataW(DataW), .AddrW(AddrW)) chk_i (.*);

// File: tb/rmw_fused_exec_tb.sv
`timescale 1ns/1ps
module rmw_fused_exec_tb_top;
  localparam int K_NONE = 0, K_NOP = 1, K_LAX = 2, K_SAX = 3, K_SBC = 4,
                 K_SLO = 5, K_RLA = 6, K_SRE = 7, K_RRA = 8, K_DCP = 9, K_ISB = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] effAddr = '0;
  logic [7:0]  aIn = '0, xIn = '0, pIn = '0;
  logic [7:0]  memRData;
  logic [15:0] memAddr;
  logic        memRd, memWr, done;
  logic [7:0]  memWData, aOut, xOut, pOut;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rmw_fused_exec dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .effAddr(effAddr),
    .aIn(aIn), .xIn(xIn), .pIn(pIn), .memRData(memRData), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWData(memWData), .done(done),
    .aOut(aOut), .xOut(xOut), .pOut(pOut)
  );

  // memory model: read data registered one cycle after memRd
  logic [7:0]  memByte = '0;
  logic [7:0]  rdQ = '0;
  int          rdCnt = 0, wrCnt = 0;
  logic [15:0] rdAddr = '0, wrAddr = '0;
  logic [7:0]  wrData = '0;
  assign memRData = rdQ;
  always @(posedge clk) begin
    if (memRd) begin rdQ <= memByte; rdCnt <= rdCnt + 1; rdAddr <= memAddr; end
    if (memWr) begin wrCnt <= wrCnt + 1; wrAddr <= memAddr; wrData <= memWData; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int classOf(input logic [7:0] op);
    case (op)
      8'h03, 8'h07, 8'h0F, 8'h13, 8'h17, 8'h1B, 8'h1F: return K_SLO;
      8'h23, 8'h27, 8'h2F, 8'h33, 8'h37, 8'h3B, 8'h3F: return K_RLA;
      8'h43, 8'h47, 8'h4F, 8'h53, 8'h57, 8'h5B, 8'h5F: return K_SRE;
      8'h63, 8'h67, 8'h6F, 8'h73, 8'h77, 8'h7B, 8'h7F: return K_RRA;
      8'h83, 8'h87, 8'h8F, 8'h97:                      return K_SAX;
      8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF:        return K_LAX;
      8'hC3, 8'hC7, 8'hCF, 8'hD3, 8'hD7, 8'hDB, 8'hDF: return K_DCP;
      8'hE3, 8'hE7, 8'hEF, 8'hF3, 8'hF7, 8'hFB, 8'hFF: return K_ISB;
      8'hEB:                                           return K_SBC;
      8'h04, 8'h0C, 8'h14, 8'h1C, 8'h34, 8'h3C, 8'h44, 8'h54,
      8'h5C, 8'h64, 8'h74, 8'h7C, 8'hD4, 8'hDC, 8'hF4, 8'hFC: return K_NOP;
      default: return K_NONE;
    endcase
  endfunction

  function automatic string reqOf(input int k);
    case (k)
      K_DCP: return "R2";
      K_ISB: return "R3";
      K_SLO, K_SRE: return "R4";
      K_RLA, K_RRA: return "R5";
      K_LAX: return "R6";
      K_SAX: return "R7";
      K_SBC: return "R8";
      K_NOP: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model of the requirements
  task automatic model(input logic [7:0] op, a, x, p, m,
                       output logic [7:0] eA, eX, eP, eWd,
                       output int eRd, eWr, eLat);
    int k;
    logic [7:0] nm, b, zn;
    logic c, cin, upd;
    logic [8:0] s;
    k = classOf(op);
    eA = a; eX = x; eP = p; nm = m; eWd = 8'h00; c = p[0];
    cin = p[0]; b = m; upd = 1'b1; zn = a;
    eRd = 1; eWr = 0; eLat = 1;
    case (k)
      K_SLO: begin nm = {m[6:0], 1'b0}; c = m[7]; eA = a | nm; end
      K_RLA: begin nm = {m[6:0], p[0]}; c = m[7]; eA = a & nm; end
      K_SRE: begin nm = {1'b0, m[7:1]}; c = m[0]; eA = a ^ nm; end
      K_RRA: begin nm = {p[0], m[7:1]}; b = nm; cin = m[0]; end
      K_DCP: nm = m - 8'd1;
      K_ISB: begin nm = m + 8'd1; b = ~nm; end
      K_SBC: b = ~m;
      default: ;
    endcase
    if (k == K_RRA || k == K_ISB || k == K_SBC) begin
      s = {1'b0, a} + {1'b0, b} + {8'd0, cin};
      eA = s[7:0]; c = s[8];
      eP[6] = (a[7] == b[7]) && (s[7] != a[7]);
    end
    if (k == K_DCP) c = (a >= nm);
    if (k == K_LAX) begin eA = m; eX = m; end
    zn = (k == K_DCP) ? (a - nm) : eA;
    upd = !(k == K_NOP || k == K_SAX || k == K_NONE);
    if (upd) begin
      eP[1] = (zn == 8'h00);
      eP[7] = zn[7];
      if (k != K_LAX) eP[0] = c;
    end
    if (k inside {K_SLO, K_RLA, K_SRE, K_RRA, K_DCP, K_ISB}) begin
      eWr = 1; eWd = nm; eLat = 5;
    end else if (k == K_LAX || k == K_SBC) eLat = 4;
    else if (k == K_NOP) eLat = 3;
    else if (k == K_SAX) begin eWr = 1; eWd = a & x; eRd = 0; eLat = 2; end
    else begin eRd = 0; eLat = 1; end
  endtask

  task automatic runOp(input logic [7:0] op, input logic [15:0] ea,
                       input logic [7:0] a, x, p, m, input int pokeAt);
    logic [7:0] eA, eX, eP, eWd;
    int eRd, eWr, eLat, lat, rd0, wr0, k;
    string rq;
    k = classOf(op);
    rq = reqOf(k);
    model(op, a, x, p, m, eA, eX, eP, eWd, eRd, eWr, eLat);
    memByte = m;
    rd0 = rdCnt; wr0 = wrCnt;
    @(negedge clk);
    opcode = op; effAddr = ea; aIn = a; xIn = x; pIn = p; start = 1'b1;
    @(negedge clk);
    lat = 1;
    while (!done && lat < 20) begin
      if (lat == pokeAt) begin
        start = 1'b1; opcode = 8'hA7; aIn = ~a; xIn = ~x; pIn = ~p; effAddr = ~ea;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R11", "latency", lat, eLat);
    chk(rq, "aOut", aOut, eA);
    chk(rq, "xOut", xOut, eX);
    chk(rq, "pOut", pOut, eP);
    chk(rq, "read count", rdCnt - rd0, eRd);
    chk(rq, "write count", wrCnt - wr0, eWr);
    if (eRd > 0) chk("R11", "read address", rdAddr, ea);
    if (eWr > 0) begin
      chk("R11", "write address", wrAddr, ea);
      chk(rq, "write data", wrData, eWd);
    end
  endtask

  initial begin : main
    int seedDummy;
    logic [7:0] pool[$];
    seedDummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 256; i++) if (classOf(8'(i)) != K_NONE) pool.push_back(8'(i));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", done, 0);
    chk("R1", "memRd", memRd, 0);
    chk("R1", "memWr", memWr, 0);
    chk("R1", "aOut", aOut, 0);
    chk("R1", "xOut", xOut, 0);
    chk("R1", "pOut", pOut, 0);

    // directed corner cases
    runOp(8'hC7, 16'h0010, 8'h10, 8'h22, 8'h00, 8'h11, 0);  // R2 equality -> carry, zero
    runOp(8'hDF, 16'h1234, 8'h05, 8'h01, 8'h41, 8'h00, 0);  // R2 wrap 00->FF
    runOp(8'hE7, 16'h00FF, 8'h00, 8'h07, 8'h01, 8'hFF, 0);  // R3 wrap FF->00
    runOp(8'hF3, 16'h8000, 8'h80, 8'h00, 8'h01, 8'h00, 0);  // R3 overflow
    runOp(8'h0F, 16'h2000, 8'h00, 8'h00, 8'h00, 8'h80, 0);  // R4 shift out, zero
    runOp(8'h47, 16'h0002, 8'h00, 8'h00, 8'h00, 8'h01, 0);  // R4 right shift out
    runOp(8'h2F, 16'h3000, 8'hFF, 8'h00, 8'h01, 8'h80, 0);  // R5 rotate in carry
    runOp(8'h6F, 16'h4000, 8'h7F, 8'h00, 8'h00, 8'h01, 0);  // R5 carry feeds add, overflow
    runOp(8'hB3, 16'h0030, 8'h99, 8'h66, 8'h80, 8'h00, 0);  // R6 zero load
    runOp(8'h8F, 16'h0400, 8'hF0, 8'h3C, 8'hFF, 8'hAA, 0);  // R7 flags kept
    runOp(8'hEB, 16'h0600, 8'h50, 8'h00, 8'h01, 8'hB0, 0);  // R8 overflow
    runOp(8'h1C, 16'h0700, 8'h12, 8'h34, 8'hC3, 8'h00, 0);  // R9
    runOp(8'h02, 16'h0800, 8'h12, 8'h34, 8'hC3, 8'h00, 0);  // R10
    runOp(8'h0B, 16'h0800, 8'h12, 8'h34, 8'h3C, 8'h01, 0);  // R10 neighbour column
    runOp(8'hAB, 16'h0800, 8'h12, 8'h34, 8'h3C, 8'h01, 0);  // R10
    runOp(8'h9B, 16'h0800, 8'h12, 8'h34, 8'h3C, 8'h01, 0);  // R10
    // R12 second start mid-operation
    begin : busyCase
      int rdB, wrB;
      runOp(8'hCF, 16'h5555, 8'h40, 8'h0F, 8'h00, 8'h41, 2);
      rdB = rdCnt; wrB = wrCnt;
      repeat (4) @(negedge clk);
      chk("R12", "no extra reads", rdCnt - rdB, 0);
      chk("R12", "no extra writes", wrCnt - wrB, 0);
      chk("R12", "idle done", done, 0);
    end

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [7:0] op;
      if (($urandom % 5) != 0) op = pool[$urandom % pool.size()];
      else                     op = 8'($urandom);
      runOp(op, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL R11 watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule